// File: doc/BRIEF.md
# Serial Backlight Level Controller

This block is a write-only serial slave for a display timing controller. It listens on a four-wire serial port and accepts 8-bit command words. Each word carries a register address and a small data field.

Only two addresses act on the block's state. The duty address sets the low five bits of a six-bit backlight intensity. The resolution address records whether the panel runs in quarter-resolution or full mode. Words sent to any other address are accepted and then ignored.

The top intensity bit comes from a discrete input, with inverted sense. A second discrete input gates backlight power. The block drives out the brightness that results from these inputs. It also pulses a one-cycle strobe each time that brightness changes. The serial data output never carries anything but zero.

All serial and discrete inputs are synchronised to the system clock. The serial clock therefore has to run well below the system clock.

Top module: `bl_serial_ctrl`

## Requirements
- R1: A word is shifted in MSB first, one bit on each rising edge of `spi_sclk` while `spi_cs_n` is low, and is committed on its eighth bit. Within the word, bits 7:5 are the register address and bits 4:0 are the data.
- R2: A word with address 2 (duty) replaces intensity bits 4:0 with its data field and leaves bit 5 unchanged.
- R3: Words with address 1, 3, 4, 5, 6 or 7 change neither the intensity nor the resolution mode.
- R4: A word with address 0 (resolution) sets `qres_o` to 1 when its data field is nonzero, and to 0 when it is zero.
- R5: Intensity bit 5 is the inverse of `lvl_msb_n_i`: a high input clears the bit and a low input sets it.
- R6: `level_o` equals the six-bit intensity while `bl_pwr_i` is high, and is 0 while `bl_pwr_i` is low. It is therefore 0 whenever the intensity is 0, and otherwise ranges up to 63.
- R7: After reset the intensity is 0x20, `level_o` is 0, `qres_o` is 0 and `level_chg_o` is 0.
- R8: A word that is cut short when `spi_cs_n` rises before its eighth bit is discarded, and the next word starts again at bit 7.
- R9: `level_chg_o` is high for exactly one cycle after each change of `level_o`, and is low otherwise.
- R10: `spi_miso` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, asynchronous to `clk` |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, held at zero |
| lvl_msb_n_i | input | 1 | Discrete input for intensity bit 5, inverted sense |
| bl_pwr_i | input | 1 | Discrete backlight power enable |
| level_o | output | 6 | Effective backlight brightness |
| qres_o | output | 1 | High when quarter-resolution mode is selected |
| level_chg_o | output | 1 | One-cycle strobe on each change of `level_o` |

## Verification
Some rules are checked by the assertions on every cycle:
- duty and resolution writes update the correct fields;
- writes to other addresses leave the intensity low bits alone;
- a rise of chip select clears the bit counter;
- the brightness is forced to zero while power is off, and otherwise follows the intensity;
- the strobe matches a change of brightness.

Other behaviour can only be shown by the bench's scenarios:
- the MSB-first framing across the synchronisers;
- the reset level of 0x20 becoming visible when power is turned on;
- a truncated word being discarded rather than merged with the next one;
- the exact number of strobes over a whole sequence of writes and input changes.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = FRAME_W - ADDR_W;
  localparam int unsigned LVL_W   = DATA_W + 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_RESOLUTION = 3'd0,
    REG_PHASE      = 3'd1,
    REG_DUTY       = 3'd2,
    REG_PWR_A      = 3'd3,
    REG_PWR_B      = 3'd4,
    REG_GPOUT      = 3'd5,
    REG_PIXCTL     = 3'd6,
    REG_POLARITY   = 3'd7
  } tc_reg_e;
endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bl_spi_rx.sv
module bl_spi_rx #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  output logic               word_vld_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               sclk_d;
  logic               sclk_rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] shreg_nxt;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign shreg_nxt = {shreg[FRAME_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sclk_d     <= sclk_s;
      word_vld_o <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= shreg_nxt;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          word_o     <= shreg_nxt;
          word_vld_o <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R8: a deselected port always restarts at the first bit
  a_r8_partial_dropped: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (bit_cnt == '0));
  // R1: a committed word is only produced while selected
  a_r1_commit_selected: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> !$past(cs_n_s));
endmodule

// File: rtl/bl_reg_bank.sv
module bl_reg_bank
  import bl_pkg::*;
#(
  parameter int unsigned FW = FRAME_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_vld_i,
  input  logic [FW-1:0]    word_i,
  input  logic             msb_n_s,
  output logic [LVL_W-1:0] intensity_o,
  output logic             qres_o
);
  localparam logic [LVL_W-1:0] RST_LEVEL = LVL_W'(1) << DATA_W;

  tc_reg_e           addr;
  logic [DATA_W-1:0] data;

  assign addr = tc_reg_e'(word_i[FW-1 -: ADDR_W]);
  assign data = word_i[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      intensity_o <= RST_LEVEL;
      qres_o      <= 1'b0;
    end else begin
      intensity_o[DATA_W] <= ~msb_n_s;
      if (word_vld_i) begin
        case (addr)
          REG_DUTY:       intensity_o[DATA_W-1:0] <= data;
          REG_RESOLUTION: qres_o <= (data != '0);
          default: ;
        endcase
      end
    end
  end

  a_r2_duty_write: assert property (@(posedge clk) disable iff (rst)
    (word_vld_i && addr == REG_DUTY) |=> (intensity_o[DATA_W-1:0] == $past(data)));
  a_r3_other_ignored: assert property (@(posedge clk) disable iff (rst)
    !(word_vld_i && addr == REG_DUTY) |=> $stable(intensity_o[DATA_W-1:0]));
  a_r4_res_mode: assert property (@(posedge clk) disable iff (rst)
    (word_vld_i && addr == REG_RESOLUTION) |=> (qres_o == ($past(data) != '0)));
  a_r5_msb_inverse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (intensity_o[DATA_W] == !$past(msb_n_s)));
endmodule

// File: rtl/bl_level_out.sv
module bl_level_out #(
  parameter int unsigned LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] intensity_i,
  input  logic          pwr_s,
  output logic [LW-1:0] level_o,
  output logic          chg_o
);
  logic [LW-1:0] level_nxt;

  assign level_nxt = pwr_s ? intensity_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= '0;
      chg_o   <= 1'b0;
    end else begin
      level_o <= level_nxt;
      chg_o   <= (level_nxt != level_o);
    end
  end

  a_r6_off_unpowered: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |=> (level_o == '0));
  a_r6_follows_level: assert property (@(posedge clk) disable iff (rst)
    pwr_s |=> (level_o == $past(intensity_i)));
  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chg_o == (level_o != $past(level_o))));
endmodule

// File: rtl/bl_serial_ctrl.sv
module bl_serial_ctrl
  import bl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             lvl_msb_n_i,
  input  logic             bl_pwr_i,
  output logic [LVL_W-1:0] level_o,
  output logic             qres_o,
  output logic             level_chg_o
);
  localparam int unsigned NSYNC = 5;
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b00010;

  logic [NSYNC-1:0]   raw_in, syn_in;
  logic               word_vld;
  logic [FRAME_W-1:0] word;
  logic [LVL_W-1:0]   intensity;

  assign raw_in   = {bl_pwr_i, lvl_msb_n_i, spi_mosi, spi_cs_n, spi_sclk};
  assign spi_miso = 1'b0;

  bl_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn_in));

  bl_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .sclk_s(syn_in[0]), .cs_n_s(syn_in[1]),
    .mosi_s(syn_in[2]), .word_vld_o(word_vld), .word_o(word));

  bl_reg_bank #(.FW(FRAME_W)) u_regs (
    .clk(clk), .rst(rst), .word_vld_i(word_vld), .word_i(word),
    .msb_n_s(syn_in[3]), .intensity_o(intensity), .qres_o(qres_o));

  bl_level_out #(.LW(LVL_W)) u_out (
    .clk(clk), .rst(rst), .intensity_i(intensity), .pwr_s(syn_in[4]),
    .level_o(level_o), .chg_o(level_chg_o));
endmodule

// File: tb/test_bl_serial_ctrl.sv
`timescale 1ns/1ps
module test_bl_serial_ctrl;
  localparam int SETTLE = 14;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, msb_n = 1'b0, pwr = 1'b0;
  logic miso, qres, chg;
  logic [5:0] level;

  int checks = 0, failures = 0;
  int quiet = 1000;
  int exp_pulses = 0, seen_pulses = 0;
  bit prev_chg = 0;
  bit done = 0;

  // behavioural reference state
  int m_low = 0, m_msb = 1, m_qres = 0, m_pwr = 0;
  int m_last_level = 0;

  always #5 clk = ~clk;

  bl_serial_ctrl i_bl_serial_ctrl (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .lvl_msb_n_i(msb_n), .bl_pwr_i(pwr), .level_o(level),
    .qres_o(qres), .level_chg_o(chg));

  function automatic int model_level();
    return m_pwr ? (m_msb * 32 + m_low) : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    int nl;
    nl = model_level();
    if (nl != m_last_level) exp_pulses++;
    m_last_level = nl;
    quiet = SETTLE;
    wait_clk(SETTLE + 2);
  endtask

  task automatic shift_bits(input logic [7:0] w, input int n);
    quiet = 1000;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = w[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  // R1: full word, MSB first, address in 7:5, data in 4:0
  task automatic send_word(input logic [2:0] a, input logic [4:0] d);
    shift_bits({a, d}, 8);
    if (a == 3'd2) m_low = d;
    if (a == 3'd0) m_qres = (d != 0);
    settle();
  endtask

  task automatic set_pwr(input logic v);
    quiet = 1000; pwr = v; m_pwr = v; settle();
  endtask

  task automatic set_msb_n(input logic v);
    quiet = 1000; msb_n = v; m_msb = !v; settle();
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R10 miso", miso, 0);
      if (chg) seen_pulses++;
      if (chg && prev_chg) check("R9 strobe width", 2, 1);
      prev_chg = chg;
      if (quiet > 0) quiet--;
      else begin
        check("R6 level", level, model_level());
        check("R4 qres", qres, m_qres);
        check("R9 strobe idle", chg, 0);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(5);
    check("R7 level in reset", level, 0);
    rst = 1'b0;
    wait_clk(3);
    check("R7 level after reset", level, 0);
    check("R7 qres after reset", qres, 0);
    check("R7 strobe after reset", chg, 0);
    quiet = 0;
    wait_clk(4);
    // R7: reset intensity 0x20 shows once powered
    set_pwr(1'b1);
    check("R7 reset intensity", level, 32);
    // R2: duty write keeps bit 5
    send_word(3'd2, 5'd5);
    check("R2 duty", level, 37);
    // R5: discrete high clears bit 5
    set_msb_n(1'b1);
    check("R5 msb cleared", level, 5);
    // R6: zero intensity gives zero output
    send_word(3'd2, 5'd0);
    check("R6 zero", level, 0);
    send_word(3'd2, 5'd31);
    set_msb_n(1'b0);
    check("R5 msb set", level, 63);
    // R3: other addresses ignored
    for (int a = 1; a < 8; a++)
      if (a != 2) send_word(a[2:0], 5'd10);
    check("R3 level unchanged", level, 63);
    check("R3 qres unchanged", qres, 0);
    // R4: resolution mode
    send_word(3'd0, 5'd1);
    check("R4 qres set", qres, 1);
    send_word(3'd0, 5'd16);
    check("R4 qres held", qres, 1);
    send_word(3'd0, 5'd0);
    check("R4 qres clear", qres, 0);
    // R8: partial word discarded
    shift_bits(8'b0100_0000, 3);
    settle();
    send_word(3'd2, 5'd9);
    check("R8 after partial", level, 41);
    // R6: power gating
    set_pwr(1'b0);
    check("R6 unpowered", level, 0);
    send_word(3'd2, 5'd3);
    check("R6 write while off", level, 0);
    set_pwr(1'b1);
    check("R6 repowered", level, 35);
    done = 1;
    check("R9 strobe count", seen_pulses, exp_pulses);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule